// File: doc/BRIEF.md
# Auto-Incrementing Shared-Memory Window

This block lets a host on a narrow register bus reach two on-board memories through one data register instead of mapping them directly. The host loads a 16-bit byte pointer, then reads or writes the data register over and over. Each access moves exactly one 16-bit word at the current pointer, and the pointer then steps forward by two bytes. The sequence is: pick a bank, set the pointer, stream words.

A bit in the control word selects the target memory. With it set, the window opens onto the larger bank. With it clear, the window opens onto the smaller one. Two scratch status words are also available for host software. The bus has separate read and write ports, each with its own address, so a read and a write can land in the same clock cycle. The rules for those collisions are fixed below. Read data is registered and appears one cycle after the read strobe.

The bank depths are parameters. By default the larger bank holds twice as many words as the smaller one. A word index is the pointer halved and taken modulo the depth of the selected bank.

Top module: `smw_window`

## Requirements
- R1: After reset the control word is 0xC000, and the pointer, both status words and the read-data output are 0.
- R2: Register decode uses the low 8 address bits: 0x18 control, 0x1C pointer, 0x20 data window, 0x24 status A, 0x28 status B. A read of control, pointer or status returns the stored 16-bit value. A write stores only bits 15:0 of the write data.
- R3: `rdata` takes the value of a read in the clock cycle after `rd_en`. It holds its value in every cycle with no read.
- R4: Each cycle with a data-window access (a read, a write, or both) adds exactly 2 to the pointer, modulo 65536.
- R5: Control bit 0 set to 1 steers the window to the large bank. Control bit 0 set to 0 steers it to the small bank. A write to one bank leaves the other bank unchanged.
- R6: The word index is the pointer divided by 2, modulo the selected bank's depth. A data write stores bits 15:0 of the write data.
- R7: A read of any undecoded address returns 0xFFFF. A write to an undecoded address changes no register and no pointer.
- R8: When the pointer is written in the same cycle as a data access, the written value wins over the increment. The data access still uses the old pointer.
- R9: A read and a write in the same cycle both see the state from before that cycle. A read of a register or memory word that is being written returns the old value.
- R10: Reads of the data window on back-to-back cycles return consecutive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 8 | Read register address (byte) |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_addr | input | 8 | Write register address (byte) |
| wdata | input | 32 | Write data, only bits 15:0 used |
| rdata | output | 16 | Registered read data |

## Verification
A pointer write can fall in the same cycle as a data-window read. A data-window read can also fall in the same cycle as a data-window write. Both collisions are driven on purpose through the separate read and write ports. The behavioural model in the bench predicts the pointer and the returned word for each case. The pointer write must win over the step, and the read must return the word from before the write. The result is judged by reading the pointer back and by comparing each registered read word against the model on every clock.

// File: rtl/smw_pkg.sv
`timescale 1ns/1ps
package smw_pkg;
    localparam int REG_W = 16;
    localparam logic [7:0] ADR_CTRL = 8'h18;
    localparam logic [7:0] ADR_PTR  = 8'h1C;
    localparam logic [7:0] ADR_DATA = 8'h20;
    localparam logic [7:0] ADR_STA  = 8'h24;
    localparam logic [7:0] ADR_STB  = 8'h28;
    localparam logic [REG_W-1:0] CTRL_RST  = 16'hC000;
    localparam logic [REG_W-1:0] MISS_DATA = 16'hFFFF;
    localparam logic [REG_W-1:0] PTR_STEP  = 16'd2;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_PTR, SEL_DATA, SEL_STA, SEL_STB
    } sel_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] ptr;
        logic [REG_W-1:0] sta;
        logic [REG_W-1:0] stb;
        logic [REG_W-1:0] rdata;
    } state_t;
endpackage

// File: rtl/smw_decode.sv
`timescale 1ns/1ps
module smw_decode
    import smw_pkg::*;
(
    input  logic [7:0] addr,
    output sel_e       sel
);
    always_comb begin
        case (addr)
            ADR_CTRL: sel = SEL_CTRL;
            ADR_PTR:  sel = SEL_PTR;
            ADR_DATA: sel = SEL_DATA;
            ADR_STA:  sel = SEL_STA;
            ADR_STB:  sel = SEL_STB;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/smw_ram.sv
`timescale 1ns/1ps
module smw_ram #(
    parameter int WORDS = 1024,
    parameter int DW    = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wdata;
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/smw_window.sv
`timescale 1ns/1ps
module smw_window
    import smw_pkg::*;
#(
    parameter int BIG_WORDS   = 2048,
    parameter int SMALL_WORDS = 1024,
    parameter int BUS_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [7:0]       rd_addr,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);
    localparam int NBANK = 2;

    state_t st_q, st_d;
    sel_e   rd_sel, wr_sel;
    logic   [REG_W-1:0] bank_rd [NBANK];
    logic   [NBANK-1:0] bank_we;
    logic   data_acc;

    smw_decode u_rd_dec (.addr(rd_addr), .sel(rd_sel));
    smw_decode u_wr_dec (.addr(wr_addr), .sel(wr_sel));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int DEPTH = (b == 1) ? BIG_WORDS : SMALL_WORDS;
        localparam int AW    = $clog2(DEPTH);
        smw_ram #(.WORDS(DEPTH), .DW(REG_W)) u_ram (
            .clk   (clk),
            .we    (bank_we[b]),
            .idx   (st_q.ptr[AW:1]),
            .wdata (wdata[REG_W-1:0]),
            .rdata (bank_rd[b])
        );
        assign bank_we[b] = wr_en && (wr_sel == SEL_DATA) && (st_q.ctrl[0] == b[0]);
    end

    always_comb begin
        st_d     = st_q;
        data_acc = (rd_en && rd_sel == SEL_DATA) || (wr_en && wr_sel == SEL_DATA);

        if (rd_en) begin
            case (rd_sel)
                SEL_CTRL: st_d.rdata = st_q.ctrl;
                SEL_PTR:  st_d.rdata = st_q.ptr;
                SEL_DATA: st_d.rdata = bank_rd[st_q.ctrl[0]];
                SEL_STA:  st_d.rdata = st_q.sta;
                SEL_STB:  st_d.rdata = st_q.stb;
                default:  st_d.rdata = MISS_DATA;
            endcase
        end

        if (data_acc) st_d.ptr = st_q.ptr + PTR_STEP;

        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: st_d.ctrl = wdata[REG_W-1:0];
                SEL_PTR:  st_d.ptr  = wdata[REG_W-1:0];
                SEL_STA:  st_d.sta  = wdata[REG_W-1:0];
                SEL_STB:  st_d.stb  = wdata[REG_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RST;
            st_q.ptr   <= '0;
            st_q.sta   <= '0;
            st_q.stb   <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/smw_window_chk.sv
`timescale 1ns/1ps
module smw_window_chk
    import smw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input sel_e             rd_sel,
    input sel_e             wr_sel,
    input logic [31:0]      wdata,
    input logic [REG_W-1:0] rdata,
    input state_t           st
);
    logic acc, ptr_wr;
    assign acc    = (rd_en && rd_sel == SEL_DATA) || (wr_en && wr_sel == SEL_DATA);
    assign ptr_wr = wr_en && wr_sel == SEL_PTR;

    // R1
    a_r1_reset_values: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (st.ctrl == CTRL_RST && st.ptr == '0 && rdata == '0));
    // R3
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    // R4
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ptr_wr) |=> st.ptr == $past(st.ptr) + 16'd2);
    // R4, R7
    a_r4_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !ptr_wr) |=> $stable(st.ptr));
    // R8
    a_r8_ptr_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> st.ptr == $past(wdata[15:0]));
    // R7
    a_r7_miss_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_NONE) |=> rdata == MISS_DATA);
endmodule

bind smw_window smw_window_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel),
    .wdata  (wdata),
    .rdata  (rdata),
    .st     (st_q)
);

// File: tb/smw_window_bench.sv
`timescale 1ns/1ps
module smw_window_bench;
    localparam int BIG   = 2048;
    localparam int SMALL = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  rd_addr = '0, wr_addr = '0;
    logic [31:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0, fails = 0;
    bit done = 0;

    int          m_ctrl = 16'hC000, m_ptr = 0, m_sta = 0, m_stb = 0;
    logic [15:0] m_rdata = 16'h0;
    logic [15:0] big_m [BIG];
    logic [15:0] small_m [SMALL];

    always #2 clk = ~clk;

    smw_window #(.BIG_WORDS(BIG), .SMALL_WORDS(SMALL), .BUS_W(32)) u_smw_window (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic cyc(input bit re, input logic [7:0] ra, input bit we,
                       input logic [7:0] wa, input logic [31:0] wd, input string req);
        logic [15:0] exp_r;
        bit acc;
        int bi, si, n_ctrl, n_ptr, n_sta, n_stb;
        exp_r = m_rdata;
        acc = 0;
        bi = (m_ptr / 2) % BIG;
        si = (m_ptr / 2) % SMALL;
        n_ctrl = m_ctrl; n_sta = m_sta; n_stb = m_stb;
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wdata = wd;
        if (re) begin
            case (ra)
                8'h18: exp_r = m_ctrl[15:0];
                8'h1C: exp_r = m_ptr[15:0];
                8'h20: begin exp_r = m_ctrl[0] ? big_m[bi] : small_m[si]; acc = 1; end
                8'h24: exp_r = m_sta[15:0];
                8'h28: exp_r = m_stb[15:0];
                default: exp_r = 16'hFFFF;
            endcase
        end
        n_ptr = m_ptr;
        if (we && wa == 8'h20) acc = 1;
        if (acc) n_ptr = (m_ptr + 2) % 65536;
        if (we) begin
            case (wa)
                8'h18: n_ctrl = int'(wd[15:0]);
                8'h1C: n_ptr  = int'(wd[15:0]);
                8'h24: n_sta  = int'(wd[15:0]);
                8'h28: n_stb  = int'(wd[15:0]);
                8'h20: if (m_ctrl[0]) big_m[bi] = wd[15:0]; else small_m[si] = wd[15:0];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_ctrl = n_ctrl; m_ptr = n_ptr; m_sta = n_sta; m_stb = n_stb; m_rdata = exp_r;
        rd_en = 1'b0; wr_en = 1'b0;
        checks++;
        if (rdata !== exp_r) begin
            fails++;
            $display("FAIL %s: rdata actual %h expected %h", req, rdata, exp_r);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        cyc(1, a, 0, 8'h00, 32'h0, req);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        cyc(0, 8'h00, 1, a, d, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, "R1");            // R1 rdata after reset
        rd(8'h18, "R1"); rd(8'h1C, "R1"); rd(8'h24, "R1"); rd(8'h28, "R1");
        // R2 register storage, upper bits dropped
        wr(8'h24, 32'h1234ABCD, "R2"); rd(8'h24, "R2");
        wr(8'h28, 32'hFFFF5A5A, "R2"); rd(8'h28, "R2");
        wr(8'h18, 32'hFFFF0000, "R2"); rd(8'h18, "R2");
        // R6 small bank stream, R4 pointer step
        wr(8'h1C, 32'h10, "R6");
        for (int i = 0; i < 5; i++) wr(8'h20, 32'hA000 + i, "R6");
        rd(8'h1C, "R4");
        wr(8'h1C, 32'h10, "R10");
        for (int i = 0; i < 5; i++) rd(8'h20, "R10");
        // R5 large bank separate
        wr(8'h18, 32'h1, "R5"); wr(8'h1C, 32'h10, "R5");
        for (int i = 0; i < 3; i++) wr(8'h20, 32'hB000 + i, "R5");
        wr(8'h1C, 32'h10, "R5");
        for (int i = 0; i < 3; i++) rd(8'h20, "R5");
        wr(8'h18, 32'h0, "R5"); wr(8'h1C, 32'h10, "R5");
        for (int i = 0; i < 3; i++) rd(8'h20, "R5");
        // R4 wrap and R6 modulo alias in small bank
        wr(8'h1C, 32'hFFFE, "R4"); wr(8'h20, 32'hCAFE, "R4"); rd(8'h1C, "R4");
        wr(8'h1C, 32'h07FE, "R6"); rd(8'h20, "R6");
        // R7 undecoded
        rd(8'h00, "R7"); rd(8'h30, "R7");
        wr(8'h2C, 32'h0000DEAD, "R7"); wr(8'h1A, 32'h0000BEEF, "R7");
        rd(8'h18, "R7"); rd(8'h1C, "R7"); rd(8'h24, "R7"); rd(8'h28, "R7");
        // R8 pointer write with concurrent data read
        wr(8'h1C, 32'h12, "R8");
        cyc(1, 8'h20, 1, 8'h1C, 32'h40, "R8");
        rd(8'h1C, "R8");
        // R9 data read and write in same cycle
        wr(8'h1C, 32'h14, "R9");
        cyc(1, 8'h20, 1, 8'h20, 32'h7777, "R9");
        rd(8'h1C, "R9");
        wr(8'h1C, 32'h14, "R9"); rd(8'h20, "R9");
        cyc(1, 8'h18, 1, 8'h18, 32'h0003, "R9"); rd(8'h18, "R9");
        // R3 hold over idle cycles
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, "R3");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule